// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block is the master side of a one-line serial bus that carries power-style open-drain signalling: every participant may only pull the shared data line low or let it float high. The engine never drives the line high. It has one output enable, `dq_oe`, that pulls the line low, and one sampled input, `dq_in`, that reads the resolved line level. All information is carried by how long the line stays low. A long low pulse resets the bus, and a slave answers it with a presence pulse. Short and long low pulses in fixed-length time slots carry a 1 or a 0 from master to slave. In a read slot the master gives a brief pulse, and the slave stretches it to return a 0.

A host issues one of three byte-level commands: bus reset, write byte or read byte. The host raises `cmd_valid` with an operation code while the engine is idle. The engine turns the command into one reset slot or eight bit slots, least significant bit first. It pulses `done` when the last slot ends. Received bits also feed a running 8-bit CRC, which a bus reset clears. After the slave's checksum byte has been read, `crc_ok` tells the host whether the data was intact. Device addressing is just a matter of writing the right command bytes. All slot timing is counted in microseconds from a tick derived from the system clock by the `TICKS_PER_US` parameter.

The top controller has five states. Idle leaves for Reset, Write or Read when a command is accepted. Reset, Write and Read move to Finish when their last slot completes. Finish returns to Idle after one cycle. The slot timer under it has three states. Idle moves to Low on a slot start. Low moves to Release when the low time has elapsed. Release moves back to Idle at the end of the slot.

Top module: `owm_engine`

## Requirements
- R1: After reset, `dq_oe`, `busy`, `done` and `presence` are 0, `rx_data` and `crc_value` are 0x00, and `crc_ok` is 1.
- R2: Operation code 2'b01 (bus reset) holds `dq_oe` high for 480 us and then releases the line. The slot lasts 960 us. The line is sampled 550 us after the pulse began, and `presence` becomes 1 if that sample was low and 0 if it was high.
- R3: Operation code 2'b10 (write byte) sends `cmd_data` as eight slots, bit 0 first. A 1 bit pulls low for 6 us and a 0 bit pulls low for 60 us. Each slot lasts 72 us: a 70 us slot plus 2 us of recovery.
- R4: Operation code 2'b11 (read byte) issues eight slots of 72 us each. Each slot pulls low for 6 us and samples the line 15 us after the slot began. The first sample is bit 0 of `rx_data`, which is updated when the command completes.
- R5: `crc_value` is updated with every received bit, LSB first, using the reflected polynomial 0x8C (x^8+x^5+x^4+1). A bus reset command clears it to 0x00. `crc_ok` is 1 exactly when `crc_value` is 0x00.
- R6: `busy` is high from the cycle after a command is accepted through the cycle in which `done` is high. `done` is a one-cycle pulse in the cycle after the last slot ends. Each slot starts one clock cycle after the previous one ends.
- R7: A command is accepted only while `busy` is low and `cmd_op` is not 2'b00. `cmd_valid` raised with 2'b00, or raised while busy, starts no activity and leaves the running command unchanged.
- R8: `dq_oe` is high only during the low phase of a slot and is never high while `busy` is low.
- R9: `rx_data` and `presence` keep their values between commands and change only in the `done` cycle of a read command or a reset command respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation: 01 bus reset, 10 write byte, 11 read byte, 00 none |
| cmd_data | input | 8 | Byte to send for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last byte read |
| presence | output | 1 | A slave answered the last bus reset |
| crc_value | output | 8 | Running CRC over received bits |
| crc_ok | output | 1 | Running CRC is zero |
| dq_oe | output | 1 | Pull the data line low |
| dq_in | input | 1 | Resolved level of the data line |

## Verification
The assertions assume that `dq_in` is the wired-AND of the engine's own pull and the slave's pull. They also assume that `cmd_valid` is only a request, so a rise of `busy` must follow a cycle in which it was high. The bench resolves the line exactly that way. Its slave model times its pulls in whole microseconds well clear of the sample points, so the two-stage input synchroniser never makes a sample ambiguous. Stray requests are only injected in the middle of a running command or with the null operation code, and the bench then checks the full line waveform and the idle period that follows.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } owm_op_e;

    typedef enum logic [1:0] {
        SK_RESET,
        SK_WRITE0,
        SK_WRITE1,
        SK_READ
    } slot_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_WRITE,
        ST_READ,
        ST_FINISH
    } eng_state_e;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_LOW,
        SL_RELEASE
    } slot_state_e;

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/owm_crc8.sv
module owm_crc8 #(
    parameter logic [7:0] POLY = 8'h8C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [7:0] crc
);
    logic fb;

    assign fb = crc[0] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 8'h00;
        end else if (clr) begin
            crc <= 8'h00;
        end else if (en) begin
            crc <= {1'b0, crc[7:1]} ^ (fb ? POLY : 8'h00);
        end
    end

endmodule

// File: rtl/owm_slot.sv
module owm_slot
    import owm_pkg::*;
#(
    parameter int TICKS_PER_US  = 50,
    parameter int RST_LOW_US    = 480,
    parameter int RST_SAMPLE_US = 70,
    parameter int RST_TOTAL_US  = 960,
    parameter int W1_LOW_US     = 6,
    parameter int W0_LOW_US     = 60,
    parameter int RD_LOW_US     = 6,
    parameter int RD_SAMPLE_US  = 15,
    parameter int SLOT_US       = 70,
    parameter int REC_US        = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  slot_kind_e kind,
    input  logic       dq_in,
    output logic       dq_oe,
    output logic       slot_done,
    output logic       slot_bit
);
    localparam int BIT_TOTAL_US = SLOT_US + REC_US;
    localparam int UW           = $clog2(RST_TOTAL_US + 1);

    slot_state_e      state, state_n;
    slot_kind_e       kind_q;
    logic [UW-1:0]    us_cnt;
    logic [1:0]       sync_q;
    logic             sample_q;
    logic             tick;
    logic [UW-1:0]    low_last, smp_last, end_last;
    logic             low_end, slot_end, smp_hit;

    owm_tick #(.DIV(TICKS_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .tick (tick)
    );

    // Per-kind timing limits, in microseconds minus one
    always_comb begin
        low_last = UW'(RD_LOW_US - 1);
        smp_last = UW'(RD_SAMPLE_US - 1);
        end_last = UW'(BIT_TOTAL_US - 1);
        unique case (kind_q)
            SK_RESET: begin
                low_last = UW'(RST_LOW_US - 1);
                smp_last = UW'(RST_LOW_US + RST_SAMPLE_US - 1);
                end_last = UW'(RST_TOTAL_US - 1);
            end
            SK_WRITE0: begin
                low_last = UW'(W0_LOW_US - 1);
                smp_last = UW'(BIT_TOTAL_US - 1);
            end
            SK_WRITE1: begin
                low_last = UW'(W1_LOW_US - 1);
                smp_last = UW'(BIT_TOTAL_US - 1);
            end
            SK_READ: begin
                low_last = UW'(RD_LOW_US - 1);
                smp_last = UW'(RD_SAMPLE_US - 1);
            end
            default: ;
        endcase
    end

    assign low_end  = tick && (us_cnt == low_last);
    assign slot_end = tick && (us_cnt == end_last);
    assign smp_hit  = tick && (us_cnt == smp_last);

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            SL_IDLE:    if (start)    state_n = SL_LOW;
            SL_LOW:     if (low_end)  state_n = SL_RELEASE;
            SL_RELEASE: if (slot_end) state_n = SL_IDLE;
            default:                  state_n = SL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SL_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Timing counter, kind latch, input synchroniser and sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= SK_RESET;
            us_cnt   <= '0;
            sync_q   <= 2'b11;
            sample_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], dq_in};
            if (state == SL_IDLE) begin
                if (start) begin
                    kind_q <= kind;
                    us_cnt <= '0;
                end
            end else begin
                if (tick) begin
                    us_cnt <= us_cnt + 1'b1;
                end
                if (smp_hit) begin
                    sample_q <= sync_q[1];
                end
            end
        end
    end

    // Outputs
    always_comb begin
        dq_oe     = (state == SL_LOW);
        slot_done = (state == SL_RELEASE) && slot_end;
        slot_bit  = sample_q;
    end

    // R6
    slot_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == SL_IDLE));

    // R8
    slot_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |-> !dq_oe);

endmodule

// File: rtl/owm_engine.sv
module owm_engine
    import owm_pkg::*;
#(
    parameter int TICKS_PER_US  = 50,
    parameter int RST_LOW_US    = 480,
    parameter int RST_SAMPLE_US = 70,
    parameter int RST_TOTAL_US  = 960,
    parameter int W1_LOW_US     = 6,
    parameter int W0_LOW_US     = 60,
    parameter int RD_LOW_US     = 6,
    parameter int RD_SAMPLE_US  = 15,
    parameter int SLOT_US       = 70,
    parameter int REC_US        = 2,
    parameter int BYTE_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BYTE_BITS-1:0] cmd_data,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rx_data,
    output logic                 presence,
    output logic [7:0]           crc_value,
    output logic                 crc_ok,
    output logic                 dq_oe,
    input  logic                 dq_in
);
    localparam int BW = $clog2(BYTE_BITS);

    eng_state_e           state, state_n;
    owm_op_e              op;
    logic [BYTE_BITS-1:0] shreg;
    logic [BW-1:0]        bit_cnt;
    logic                 kick;
    logic [BYTE_BITS-1:0] rx_q;
    logic                 pres_q;
    logic                 accept;
    logic                 last_bit;
    slot_kind_e           kind;
    logic                 slot_done, slot_bit;
    logic [BYTE_BITS-1:0] rx_next;

    assign op       = owm_op_e'(cmd_op);
    assign accept   = (state == ST_IDLE) && cmd_valid && (op != OP_NONE);
    assign last_bit = (bit_cnt == BW'(BYTE_BITS - 1));
    assign rx_next  = {slot_bit, shreg[BYTE_BITS-1:1]};

    // Slot kind for the next slot start
    always_comb begin
        unique case (state)
            ST_RESET: kind = SK_RESET;
            ST_READ:  kind = SK_READ;
            ST_WRITE: kind = shreg[0] ? SK_WRITE1 : SK_WRITE0;
            default:  kind = SK_RESET;
        endcase
    end

    owm_slot #(
        .TICKS_PER_US (TICKS_PER_US),
        .RST_LOW_US   (RST_LOW_US),
        .RST_SAMPLE_US(RST_SAMPLE_US),
        .RST_TOTAL_US (RST_TOTAL_US),
        .W1_LOW_US    (W1_LOW_US),
        .W0_LOW_US    (W0_LOW_US),
        .RD_LOW_US    (RD_LOW_US),
        .RD_SAMPLE_US (RD_SAMPLE_US),
        .SLOT_US      (SLOT_US),
        .REC_US       (REC_US)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (kick),
        .kind     (kind),
        .dq_in    (dq_in),
        .dq_oe    (dq_oe),
        .slot_done(slot_done),
        .slot_bit (slot_bit)
    );

    owm_crc8 #(.POLY(8'h8C)) u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept && (op == OP_RESET)),
        .en   ((state == ST_READ) && slot_done),
        .din  (slot_bit),
        .crc  (crc_value)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_RESET: state_n = ST_RESET;
                        OP_WRITE: state_n = ST_WRITE;
                        OP_READ:  state_n = ST_READ;
                        default:  state_n = ST_IDLE;
                    endcase
                end
            end
            ST_RESET:  if (slot_done)             state_n = ST_FINISH;
            ST_WRITE:  if (slot_done && last_bit) state_n = ST_FINISH;
            ST_READ:   if (slot_done && last_bit) state_n = ST_FINISH;
            ST_FINISH:                            state_n = ST_IDLE;
            default:                              state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Byte serialiser and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            kick    <= 1'b0;
            rx_q    <= '0;
            pres_q  <= 1'b0;
        end else begin
            kick <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        shreg   <= cmd_data;
                        bit_cnt <= '0;
                        kick    <= 1'b1;
                    end
                end
                ST_RESET: begin
                    if (slot_done) begin
                        pres_q <= ~slot_bit;
                    end
                end
                ST_WRITE: begin
                    if (slot_done && !last_bit) begin
                        shreg   <= shreg >> 1;
                        bit_cnt <= bit_cnt + 1'b1;
                        kick    <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (slot_done) begin
                        shreg <= rx_next;
                        if (last_bit) begin
                            rx_q <= rx_next;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            kick    <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
        rx_data  = rx_q;
        presence = pres_q;
        crc_ok   = (crc_value == 8'h00);
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dq_oe);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> done);

    // R9
    pres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> done);

endmodule

// File: tb/tb_owm_engine.sv
module tb_owm_engine;

    localparam int T = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       busy, done, presence, crc_ok, dq_oe, dq_in;
    logic [7:0] rx_data, crc_value;
    logic       slave_pull = 1'b0;

    int n_total = 0;
    int n_bad   = 0;
    bit finished = 1'b0;
    logic [7:0] ref_crc = 8'h00;

    always #10 clk = ~clk;

    assign dq_in = ~(dq_oe | slave_pull);

    owm_engine #(.TICKS_PER_US(T)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_data (cmd_data),
        .busy     (busy),
        .done     (done),
        .rx_data  (rx_data),
        .presence (presence),
        .crc_value(crc_value),
        .crc_ok   (crc_ok),
        .dq_oe    (dq_oe),
        .dq_in    (dq_in)
    );

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    task automatic chk(input string req, input bit ok, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // op: 1 reset, 2 write, 3 read. Drives the command and acts as the slave,
    // comparing line, busy and done against the expected timeline every cycle.
    task automatic run_cmd(input int op, input logic [7:0] data, input bit slave_on,
                           input logic [7:0] sbyte, input bit inject, input string req);
        int nslots = (op == 1) ? 1 : 8;
        int mism = 0;
        int first_c = -1;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_data  = data;
        for (int s = 0; s < nslots; s++) begin
            int low   = (op == 1) ? 480 : (op == 2 ? (data[s] ? 6 : 60) : 6);
            int total = (op == 1) ? 960 : 72;
            int period = total * T + 1;
            for (int c = 0; c < period; c++) begin
                int us;
                bit exp_oe;
                @(negedge clk);
                if (inject && s == 1 && c == 3) begin
                    cmd_valid = 1'b1;
                    cmd_op    = 2'b11;
                end else begin
                    cmd_valid = 1'b0;
                end
                us = (c == 0) ? -1 : (c - 1) / T;
                exp_oe = (c >= 1) && (c <= low * T);
                slave_pull = slave_on &&
                    (((op == 1) && us >= 500 && us < 620) ||
                     ((op == 3) && !sbyte[s] && us >= 0 && us < 30));
                if (dq_oe !== exp_oe || busy !== 1'b1 || done !== 1'b0) begin
                    if (mism == 0) first_c = s * 100000 + c;
                    mism++;
                end
            end
        end
        @(negedge clk);
        slave_pull = 1'b0;
        chk("R6", done === 1'b1 && busy === 1'b1, "done pulse after last slot", int'(done), 1);
        chk(req, mism == 0, "line/busy timeline mismatches (first slot*100000+cycle in log)", mism, 0);
        if (mism != 0) $display("  first mismatch at %0d", first_c);
        @(negedge clk);
        chk("R6", done === 1'b0 && busy === 1'b0 && dq_oe === 1'b0, "return to idle", int'(busy), 0);
    endtask

    task automatic idle_watch(input int cycles, input string req);
        int act = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (busy !== 1'b0 || dq_oe !== 1'b0) act++;
        end
        chk(req, act == 0, "no activity while idle", act, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rom [0:6];
        rom[0] = 8'h28; rom[1] = 8'hFF; rom[2] = 8'h1C; rom[3] = 8'h42;
        rom[4] = 8'h91; rom[5] = 8'h00; rom[6] = 8'h7E;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", dq_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "idle outputs", int'(busy), 0);
        chk("R1", presence === 1'b0 && rx_data === 8'h00, "presence/rx", int'(rx_data), 0);
        chk("R1", crc_value === 8'h00 && crc_ok === 1'b1, "crc at reset", int'(crc_value), 0);

        // R7 null operation code ignored
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'b00;
        idle_watch(20, "R7");

        // R2 bus reset with a slave answering
        run_cmd(1, 8'h00, 1'b1, 8'h00, 1'b0, "R2");
        chk("R2", presence === 1'b1, "presence with slave", int'(presence), 1);

        // R2 bus reset with nobody on the line
        run_cmd(1, 8'h00, 1'b0, 8'h00, 1'b0, "R2");
        chk("R2", presence === 1'b0, "presence without slave", int'(presence), 0);

        // R3 write byte, mixed bits
        run_cmd(2, 8'hA5, 1'b0, 8'h00, 1'b0, "R3");
        chk("R9", presence === 1'b0 && rx_data === 8'h00, "values held over write", int'(rx_data), 0);

        // R7 request during a running write is ignored
        run_cmd(2, 8'h3C, 1'b0, 8'h00, 1'b1, "R7");
        idle_watch(30, "R7");

        // R5 reset clears CRC, then read a frame and its checksum
        run_cmd(1, 8'h00, 1'b1, 8'h00, 1'b0, "R2");
        ref_crc = 8'h00;
        chk("R5", crc_value === 8'h00, "crc cleared by bus reset", int'(crc_value), 0);
        for (int k = 0; k < 7; k++) begin
            run_cmd(3, 8'h00, 1'b1, rom[k], 1'b0, "R4");
            ref_crc = crc_step(ref_crc, rom[k]);
            chk("R4", rx_data === rom[k], "read byte", int'(rx_data), int'(rom[k]));
            chk("R5", crc_value === ref_crc, "running crc", int'(crc_value), int'(ref_crc));
        end
        run_cmd(3, 8'h00, 1'b1, ref_crc, 1'b0, "R4");
        chk("R5", crc_value === 8'h00 && crc_ok === 1'b1, "good checksum", int'(crc_value), 0);

        // R9 rx_data held across a write
        run_cmd(2, 8'hFF, 1'b0, 8'h00, 1'b0, "R3");
        chk("R9", rx_data === ref_crc, "rx held", int'(rx_data), int'(ref_crc));

        // R5 corrupted checksum
        run_cmd(1, 8'h00, 1'b1, 8'h00, 1'b0, "R2");
        ref_crc = crc_step(8'h00, 8'h55);
        run_cmd(3, 8'h00, 1'b1, 8'h55, 1'b0, "R4");
        chk("R4", rx_data === 8'h55, "read 0x55", int'(rx_data), 8'h55);
        run_cmd(3, 8'h00, 1'b1, ref_crc ^ 8'h01, 1'b0, "R4");
        ref_crc = crc_step(ref_crc, ref_crc ^ 8'h01);
        chk("R5", crc_ok === 1'b0 && crc_value === ref_crc, "bad checksum", int'(crc_value), int'(ref_crc));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule